// File: doc/BRIEF.md
# Dual-Window Boxcar Pixel Sampler

This block takes a stream of fast ADC samples from a pulsed pixel output whose period timing is known ahead of time. A pixel-start strobe marks the beginning of each period. From that strobe the block counts valid samples and uses two programmable windows. One window covers the reference (baseline) plateau and the other covers the data plateau. Samples outside both windows are discarded. This covers the reset glitch and the level transitions.

The reference window is de-integrated and the data window is integrated. Each sum is divided by its sample count, so the output is the data average minus the reference average. It is a signed baseline-corrected level, produced once per pixel without stalling the input. The default mode needs power-of-two window lengths so that each divide is a shift. A threshold mode keeps only data samples above a programmable level. It divides by the count of accepted samples using a short bit-serial divider. If no samples are accepted, it reports zero and an empty flag.

Top module: `boxcar_pixel_sampler`

## Requirements
- R1: While reset is held and after it is released, `res_valid`, `res_data` and `res_empty` are all zero until the first result.
- R2: A valid sample arriving in the same cycle as `pix_start` has index 0. Each later valid sample has the next index, and cycles with `smp_valid` low are skipped. A sample is in a window when start <= index < start + length.
- R3: In fixed mode (`cfg_thr_mode` = 0), with both lengths powers of two, the result is floor(data sum / data length) - floor(reference sum / reference length). It is given as signed two's complement of SAMPLE_W+1 bits.
- R4: Samples whose index lies in neither window have no effect on the result, whatever their value.
- R5: In fixed mode, `res_valid` is a one-cycle pulse. It is high in the cycle that follows the clock edge after the edge that takes the last data-window sample.
- R6: In threshold mode (`cfg_thr_mode` = 1), a data-window sample counts only when strictly greater than `cfg_thr`. The result is floor(accepted sum / accepted count) - floor(reference sum / reference length). It appears no later than SAMPLE_W+WIN_W+2 edges after the last data-window sample.
- R7: If threshold mode accepts no sample, the result is 0 with `res_empty` = 1. Any result with accepted samples has `res_empty` = 0, and `res_empty` changes only with a result.
- R8: Window, mode and threshold settings are captured at `pix_start`. Changing them mid-pixel does not alter that pixel's result.
- R9: Both sums and the accepted count restart at every `pix_start`. A pixel cut short by a new strobe before its data window closes gives no result and leaves nothing in the next pixel.
- R10: No result is produced before the first `pix_start` after reset.
- R11: A result never takes the most negative value of its width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_start | input | 1 | Start of a pixel period |
| smp_valid | input | 1 | Sample present this cycle |
| smp_data | input | SAMPLE_W | Unsigned ADC sample |
| cfg_ref_start | input | WIN_W | Reference window first index |
| cfg_ref_len | input | WIN_W | Reference window length (power of two) |
| cfg_dat_start | input | WIN_W | Data window first index |
| cfg_dat_len | input | WIN_W | Data window length |
| cfg_thr_mode | input | 1 | 0 fixed average, 1 threshold-gated data average |
| cfg_thr | input | SAMPLE_W | Acceptance threshold for data samples |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | SAMPLE_W+1 | Signed data-minus-reference average |
| res_empty | output | 1 | Last threshold result had no accepted sample |

## Verification
The bench sweeps every pair of power-of-two lengths from 1 to 8, with and without invalid-sample gaps. An off-by-one window edge would pull a glitch value into a sum, and a wrong shift would scale one average. Gaps and in-window index counting catch a counter that advances on invalid cycles. Threshold runs put a sample exactly at the threshold, which an inclusive compare would accept, and run an all-rejected window, where a design without the empty path would divide by zero. Mid-pixel configuration changes and truncated pixels expose settings that are not captured at the strobe and sums that carry over.

// File: rtl/boxcar_pixel_sampler.sv
module boxcar_pixel_sampler #(
  parameter int SAMPLE_W = 12,
  parameter int WIN_W    = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       pix_start,
  input  logic                       smp_valid,
  input  logic [SAMPLE_W-1:0]        smp_data,
  input  logic [WIN_W-1:0]           cfg_ref_start,
  input  logic [WIN_W-1:0]           cfg_ref_len,
  input  logic [WIN_W-1:0]           cfg_dat_start,
  input  logic [WIN_W-1:0]           cfg_dat_len,
  input  logic                       cfg_thr_mode,
  input  logic [SAMPLE_W-1:0]        cfg_thr,
  output logic                       res_valid,
  output logic signed [SAMPLE_W:0]   res_data,
  output logic                       res_empty
);
  localparam int IDX_W  = WIN_W + 1;
  localparam int ACC_W  = SAMPLE_W + WIN_W;
  localparam int SH_W   = $clog2(WIN_W);
  localparam int STEP_W = $clog2(ACC_W + 1);

  function automatic logic [SH_W-1:0] log2_of(input logic [WIN_W-1:0] v);
    logic [SH_W-1:0] r;
    r = '0;
    for (int i = 0; i < WIN_W; i++)
      if (v[i]) r = SH_W'(i);
    return r;
  endfunction

  logic [WIN_W-1:0]    r_rs, r_rl, r_ds, r_dl;
  logic                r_mode, live, close_d, busy;
  logic [SAMPLE_W-1:0] r_thr, hold_ref;
  logic [IDX_W-1:0]    idx, dat_cnt, dvs;
  logic [ACC_W-1:0]    ref_sum, dat_sum, dvd;
  logic [IDX_W:0]      rem;
  logic [STEP_W-1:0]   step;

  wire [WIN_W-1:0]    c_rs   = pix_start ? cfg_ref_start : r_rs;
  wire [WIN_W-1:0]    c_rl   = pix_start ? cfg_ref_len   : r_rl;
  wire [WIN_W-1:0]    c_ds   = pix_start ? cfg_dat_start : r_ds;
  wire [WIN_W-1:0]    c_dl   = pix_start ? cfg_dat_len   : r_dl;
  wire                c_mode = pix_start ? cfg_thr_mode  : r_mode;
  wire [SAMPLE_W-1:0] c_thr  = pix_start ? cfg_thr       : r_thr;
  wire [IDX_W-1:0]    cur    = pix_start ? '0 : idx;
  wire                take   = smp_valid && (pix_start || live);

  wire [IDX_W-1:0] ref_end = {1'b0, c_rs} + {1'b0, c_rl};
  wire [IDX_W-1:0] dat_end = {1'b0, c_ds} + {1'b0, c_dl};
  wire in_ref   = take && cur >= {1'b0, c_rs} && cur < ref_end;
  wire in_dat   = take && cur >= {1'b0, c_ds} && cur < dat_end;
  wire accept   = in_dat && (!c_mode || smp_data > c_thr);
  wire dat_last = in_dat && cur == dat_end - 1'b1;

  wire [ACC_W-1:0] smp_ext = ACC_W'(smp_data);
  wire [ACC_W-1:0] ref_shr = ref_sum >> log2_of(r_rl);
  wire [ACC_W-1:0] dat_shr = dat_sum >> log2_of(r_dl);
  wire [SAMPLE_W-1:0] ref_avg = ref_shr[SAMPLE_W-1:0];
  wire [SAMPLE_W-1:0] dat_avg = dat_shr[SAMPLE_W-1:0];

  wire [IDX_W:0] rem_sh = {rem[IDX_W-1:0], dvd[ACC_W-1]};
  wire           ge     = rem_sh >= {1'b0, dvs};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {r_rs, r_rl, r_ds, r_dl} <= '0;
      r_mode <= 1'b0;
      r_thr  <= '0;
      idx    <= '0;
      live   <= 1'b0;
    end else begin
      if (pix_start) begin
        r_rs <= cfg_ref_start; r_rl <= cfg_ref_len;
        r_ds <= cfg_dat_start; r_dl <= cfg_dat_len;
        r_mode <= cfg_thr_mode; r_thr <= cfg_thr;
        idx <= smp_valid ? IDX_W'(1) : '0;
      end else if (smp_valid && idx != '1) begin
        idx <= idx + 1'b1;
      end
      if (dat_last)       live <= 1'b0;
      else if (pix_start) live <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_sum <= '0; dat_sum <= '0; dat_cnt <= '0; close_d <= 1'b0;
    end else begin
      ref_sum <= (pix_start ? '0 : ref_sum) + (in_ref ? smp_ext : '0);
      dat_sum <= (pix_start ? '0 : dat_sum) + (accept ? smp_ext : '0);
      dat_cnt <= (pix_start ? '0 : dat_cnt) + IDX_W'(accept);
      close_d <= dat_last;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0; res_data <= '0; res_empty <= 1'b0;
      busy <= 1'b0; step <= '0; dvd <= '0; dvs <= '0; rem <= '0; hold_ref <= '0;
    end else begin
      res_valid <= 1'b0;
      if (close_d && !r_mode) begin
        res_valid <= 1'b1;
        res_empty <= 1'b0;
        res_data  <= $signed({1'b0, dat_avg}) - $signed({1'b0, ref_avg});
      end else if (close_d && dat_cnt == '0) begin
        res_valid <= 1'b1;
        res_empty <= 1'b1;
        res_data  <= '0;
      end else if (close_d) begin
        busy <= 1'b1; step <= '0; rem <= '0;
        dvd <= dat_sum; dvs <= dat_cnt; hold_ref <= ref_avg;
      end else if (busy) begin
        if (step == STEP_W'(ACC_W)) begin
          busy      <= 1'b0;
          res_valid <= 1'b1;
          res_empty <= 1'b0;
          res_data  <= $signed({1'b0, dvd[SAMPLE_W-1:0]}) - $signed({1'b0, hold_ref});
        end else begin
          rem  <= ge ? rem_sh - {1'b0, dvs} : rem_sh;
          dvd  <= {dvd[ACC_W-2:0], ge};
          step <= step + 1'b1;
        end
      end
    end
  end
endmodule

module boxcar_pixel_sampler_chk #(
  parameter int SAMPLE_W = 12
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     pix_start,
  input logic                     busy,
  input logic                     res_valid,
  input logic signed [SAMPLE_W:0] res_data,
  input logic                     res_empty
);
  logic seen;
  always_ff @(posedge clk)
    if (!rst_n) seen <= 1'b0;
    else if (pix_start) seen <= 1'b1;

  a_r7_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_empty |-> res_data == '0);
  a_r7_empty_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> $stable(res_empty));
  a_r10_no_early_result: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> seen);
  a_r11_range: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_data != {1'b1, {SAMPLE_W{1'b0}}});
  a_r6_div_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !res_valid);
  a_r5_pulse_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |=> res_valid || $stable(res_data));
endmodule

bind boxcar_pixel_sampler boxcar_pixel_sampler_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pix_start(pix_start), .busy(busy),
  .res_valid(res_valid), .res_data(res_data), .res_empty(res_empty));

// File: tb/boxcar_pixel_sampler_tb.sv
module boxcar_pixel_sampler_tb;
  localparam int CLK_P = 10;
  localparam int SW = 12;
  localparam int WW = 8;
  localparam int ACCW = SW + WW;

  logic clk = 0, rst_n = 0, pix_start = 0, smp_valid = 0, cfg_thr_mode = 0;
  logic [SW-1:0] smp_data = '0, cfg_thr = '0;
  logic [WW-1:0] cfg_ref_start = '0, cfg_ref_len = '0, cfg_dat_start = '0, cfg_dat_len = '0;
  logic res_valid, res_empty;
  logic signed [SW:0] res_data;

  boxcar_pixel_sampler #(.SAMPLE_W(SW), .WIN_W(WW)) u_dut (
    .clk(clk), .rst_n(rst_n), .pix_start(pix_start), .smp_valid(smp_valid),
    .smp_data(smp_data), .cfg_ref_start(cfg_ref_start), .cfg_ref_len(cfg_ref_len),
    .cfg_dat_start(cfg_dat_start), .cfg_dat_len(cfg_dat_len),
    .cfg_thr_mode(cfg_thr_mode), .cfg_thr(cfg_thr),
    .res_valid(res_valid), .res_data(res_data), .res_empty(res_empty));

  always #(CLK_P/2) clk = ~clk;

  int cyc = 0, checks = 0, errors = 0;
  int got_n = 0, got_cyc = 0, got_val = 0, got_emp = 0;
  always @(posedge clk) cyc++;
  always @(negedge clk) if (res_valid) begin
    got_n++; got_cyc = cyc; got_val = int'(res_data); got_emp = int'(res_empty);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sval(input int seed, input int k);
    return (seed * 733 + k * 97 + (k % 5) * 401) % 4096;
  endfunction

  // nsamp < 0 : run full pixel; otherwise stop after nsamp cycles (truncated pixel)
  task automatic pixel(input int rs, input int rl, input int ds, input int dl,
                       input bit mode, input int thr, input int seed,
                       input bit gaps, input bit chg, input int nsamp, input string tag);
    int k = 0, rsum = 0, dsum = 0, dcnt = 0, last_edge = 0, total, n = 0, exp, ravg;
    total = ds + dl + 4;
    got_n = 0;
    while (k < total && (nsamp < 0 || n < nsamp)) begin
      @(negedge clk);
      pix_start = (n == 0);
      smp_valid = !(gaps && n % 3 == 2);
      if (n == 0) begin
        cfg_ref_start = WW'(rs); cfg_ref_len = WW'(rl);
        cfg_dat_start = WW'(ds); cfg_dat_len = WW'(dl);
        cfg_thr_mode = mode; cfg_thr = SW'(thr);
      end else if (chg) begin
        cfg_ref_start = 8'd0; cfg_ref_len = 8'd1; cfg_dat_start = 8'd1;
        cfg_dat_len = 8'd1; cfg_thr_mode = !mode; cfg_thr = 12'd5;
      end
      if (smp_valid) begin
        smp_data = SW'(sval(seed, k));
        if (k < rs || (k >= rs + rl && k < ds)) smp_data = 12'hFFF; // glitch/transitions
        if (k >= ds + dl) smp_data = 12'hFFF;
        if (k >= rs && k < rs + rl) rsum += int'(smp_data);
        if (k >= ds && k < ds + dl && (!mode || int'(smp_data) > thr)) begin
          dsum += int'(smp_data); dcnt++;
        end
        if (k == ds + dl - 1) last_edge = cyc + 1;
        k++;
      end
      n++;
    end
    @(negedge clk); pix_start = 0; smp_valid = 0;
    repeat (ACCW + 8) @(negedge clk);
    if (nsamp >= 0) begin
      chk(got_n == 0, {"R9 truncated ", tag}, got_n, 0);
      return;
    end
    ravg = rsum / rl;
    if (mode && dcnt == 0) exp = 0;
    else if (mode) exp = dsum / dcnt - ravg;
    else exp = dsum / dl - ravg;
    chk(got_n == 1, {"R5 single pulse ", tag}, got_n, 1);
    if (!mode) chk(got_val == exp, {"R3 value ", tag}, got_val, exp);
    else chk(got_val == exp, {"R6 value ", tag}, got_val, exp);
    chk(got_val != -4096, {"R11 range ", tag}, got_val, exp);
    if (!mode) chk(got_cyc == last_edge + 1, {"R5 latency ", tag}, got_cyc - last_edge, 1);
    else if (dcnt > 0) chk(got_cyc - last_edge <= ACCW + 2, {"R6 latency ", tag}, got_cyc - last_edge, ACCW + 2);
    if (mode && dcnt == 0) chk(got_emp == 1, {"R7 empty set ", tag}, got_emp, 1);
    else chk(got_emp == 0, {"R7 empty clear ", tag}, got_emp, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(res_valid == 0 && res_data == 0 && res_empty == 0, "R1 in reset", int'(res_valid), 0);
    rst_n = 1;
    cfg_ref_start = 8'd0; cfg_ref_len = 8'd1; cfg_dat_start = 8'd1; cfg_dat_len = 8'd1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); smp_valid = 1; smp_data = SW'(i * 300);
    end
    @(negedge clk); smp_valid = 0;
    repeat (4) @(negedge clk);
    chk(got_n == 0, "R10 no result before strobe", got_n, 0);
    chk(res_valid == 0 && res_data == 0 && res_empty == 0, "R1 after reset", int'(res_data), 0);

    for (int g = 0; g < 2; g++)
      for (int rlg = 0; rlg < 4; rlg++)
        for (int dlg = 0; dlg < 4; dlg++)
          pixel(2, 1 << rlg, 2 + (1 << rlg) + 3, 1 << dlg, 0, 0,
                rlg * 4 + dlg + g * 16, g[0], 0, -1, "R2 R4 sweep");

    pixel(0, 4, 4, 4, 0, 0, 7, 0, 0, -1, "R2 adjacent windows");
    pixel(3, 2, 9, 8, 0, 0, 9, 1, 1, -1, "R8 mid-pixel change");
    pixel(3, 4, 10, 4, 1, 1000, 11, 0, 1, -1, "R8 threshold change");
    pixel(1, 4, 8, 6, 0, 0, 3, 0, 0, 9, "partial");
    pixel(1, 4, 8, 4, 0, 0, 4, 0, 0, -1, "R9 after truncation");
    for (int t = 0; t < 4; t++)
      pixel(2, 2, 6, 3 + t * 2, 1, 800 * t + 500, 20 + t, t[0], 0, -1, "R6 sweep");
    pixel(2, 2, 6, 5, 1, sval(30, 6), 30, 0, 0, -1, "R6 equal to threshold");
    pixel(2, 4, 8, 6, 1, 4095, 31, 0, 0, -1, "R7 none accepted");
    pixel(2, 4, 8, 6, 1, 0, 32, 1, 0, -1, "R7 after empty");
    pixel(1, 8, 12, 8, 0, 0, 33, 0, 0, -1, "R3 long windows");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule